// File: doc/BRIEF.md
# Priority Interrupt Resolver

This block gathers eight interrupt request lines into a pending register. It holds a mask register and an in-service register beside the pending one. From pending requests that are not masked, it picks the most urgent, with input 0 the most urgent and input 7 the least. It raises one interrupt line to the processor only when that request outranks everything already being serviced.

When the processor acknowledges, the chosen request moves from pending into in-service. One cycle later an 8-bit vector appears: a programmable 5-bit base in the upper bits and the 3-bit input number in the lower bits. A flag appears with the vector telling whether that input is marked as carrying a downstream controller. In-service bits are released by a non-specific end-of-interrupt command, which clears the most urgent bit that is set. In automatic mode an acknowledge never sets an in-service bit at all.

Configuration comes as already-decoded fields from a separate register front end: trigger mode, automatic-release mode, vector base, downstream-controller flags, and mask writes.

Top module: `irq_resolver`

## Requirements
- R1: After reset the pending, mask and in-service registers are all zero, `int_req` is low and `vec_valid` is low.
- R2: With `cfg_level` = 0 (edge mode), a 0-to-1 transition on `irq_in[i]` sets pending bit i at the next clock edge. The bit stays set after the input falls or while it stays high. It is cleared only when request i is acknowledged, and an input that stays high does not set it again.
- R3: With `cfg_level` = 1 (level mode), each pending bit equals its input as sampled at the previous clock edge, so dropping an input before acknowledge withdraws the request.
- R4: A masked request (mask bit = 1) is still recorded in the pending register but never causes `int_req` to be high.
- R5: Priority is fixed, with input 0 the most urgent. An acknowledge (`inta` high for one cycle while `int_req` is high) moves the most urgent unmasked pending request into in-service, setting its bit.
- R6: `int_req` is high exactly when some unmasked pending request has a smaller index than every set in-service bit. A request equal to or below an active level waits.
- R7: A one-cycle `eoi` pulse clears only the lowest-index set in-service bit.
- R8: With `cfg_auto_eoi` = 1, an acknowledge leaves the in-service register unchanged.
- R9: One cycle after any `inta` pulse, `vec_valid` is high for one cycle and `vec_out` = {`cfg_base`, 3-bit granted input number}.
- R10: An `inta` while `int_req` is low changes no register and returns the vector {`cfg_base`, 3'b111}.
- R11: `vec_slave` is high with the vector when bit i of `cfg_slave` is set for the granted input i. It is low for a vector returned under R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_in | input | 8 | Interrupt request lines |
| cfg_level | input | 1 | 1 = level trigger, 0 = edge trigger |
| cfg_auto_eoi | input | 1 | 1 = release in-service automatically |
| cfg_base | input | 5 | Upper five bits of the vector |
| cfg_slave | input | 8 | Inputs that carry a downstream controller |
| mask_we | input | 1 | Write strobe for the mask register |
| mask_wdata | input | 8 | New mask value |
| eoi | input | 1 | Non-specific end-of-interrupt pulse |
| inta | input | 1 | Acknowledge pulse from the processor |
| int_req | output | 1 | Interrupt request to the processor |
| vec_valid | output | 1 | Vector is valid this cycle |
| vec_out | output | 8 | Interrupt vector |
| vec_slave | output | 1 | Granted input carries a downstream controller |
| irr_out | output | 8 | Pending register contents |
| imr_out | output | 8 | Mask register contents |
| isr_out | output | 8 | In-service register contents |

## Verification
Cycle-level properties are checked every cycle. No request raises the output while every pending bit is masked. An acknowledge adds exactly one in-service bit, an end-of-interrupt removes exactly one, and automatic mode leaves in-service untouched. Edge-latched bits are kept until acknowledged, level-mode bits track the input, and each acknowledge produces exactly one vector pulse. Which bit is chosen, the exact vector and flag, and blocking by equal or higher levels in service can only be shown by the bench scenarios. The same holds for the spurious acknowledge and for inputs held high in edge mode.

// File: rtl/irq_pkg.sv
package irq_pkg;
    localparam int unsigned IRQ_N  = 8;
    localparam int unsigned IDX_W  = $clog2(IRQ_N);
    localparam int unsigned VEC_W  = 8;
    localparam int unsigned BASE_W = VEC_W - IDX_W;

    typedef logic [IRQ_N-1:0]  irq_vec_t;
    typedef logic [IDX_W-1:0]  irq_idx_t;
    typedef logic [BASE_W-1:0] irq_base_t;
endpackage

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
    parameter int unsigned W  = 8,
    parameter int unsigned IW = $clog2(W)
) (
    input  logic [W-1:0]  req,
    output logic          found,
    output logic [IW-1:0] idx
);
    // lowest index wins: scan from the top so the last hit is the smallest
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = W - 1; i >= 0; i--) begin
            if (req[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_request_reg.sv
module irq_request_reg
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t irq_in,
    input  logic     level_mode,
    input  irq_vec_t ack_clr,
    output irq_vec_t irr
);
    typedef struct packed {
        irq_vec_t irr;
        irq_vec_t prev;
    } req_st_t;

    req_st_t s_d, s_q;
    irq_vec_t rise;

    always_comb begin
        s_d      = s_q;
        rise     = irq_in & ~s_q.prev;
        s_d.prev = irq_in;
        if (level_mode) begin
            s_d.irr = irq_in;
        end else begin
            s_d.irr = (s_q.irr & ~ack_clr) | rise;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign irr = s_q.irr;

    // edge mode: no pending bit is lost unless acknowledged
    assert_edge_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!level_mode && ack_clr == '0) |=> ((irr & $past(irr)) == $past(irr)));

    // level mode: pending follows the sampled input
    assert_level_track_R3: assert property (@(posedge clk) disable iff (!rst_n)
        level_mode |=> (irr == $past(irq_in)));
endmodule

// File: rtl/irq_inservice_reg.sv
module irq_inservice_reg
    import irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  irq_vec_t set_bits,
    input  irq_vec_t clr_bits,
    output irq_vec_t isr
);
    typedef struct packed {
        irq_vec_t isr;
    } svc_st_t;

    svc_st_t s_d, s_q;

    always_comb begin
        s_d     = s_q;
        s_d.isr = (s_q.isr & ~clr_bits) | set_bits;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign isr = s_q.isr;
endmodule

// File: rtl/irq_resolver.sv
module irq_resolver
    import irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IRQ_N-1:0]  irq_in,
    input  logic              cfg_level,
    input  logic              cfg_auto_eoi,
    input  logic [BASE_W-1:0] cfg_base,
    input  logic [IRQ_N-1:0]  cfg_slave,
    input  logic              mask_we,
    input  logic [IRQ_N-1:0]  mask_wdata,
    input  logic              eoi,
    input  logic              inta,
    output logic              int_req,
    output logic              vec_valid,
    output logic [VEC_W-1:0]  vec_out,
    output logic              vec_slave,
    output logic [IRQ_N-1:0]  irr_out,
    output logic [IRQ_N-1:0]  imr_out,
    output logic [IRQ_N-1:0]  isr_out
);
    typedef struct packed {
        irq_vec_t         imr;
        logic [VEC_W-1:0] vec;
        logic             vec_valid;
        logic             slave;
    } top_st_t;

    top_st_t s_d, s_q;

    irq_vec_t irr, isr, req, ack_onehot, eoi_onehot, isr_set;
    logic     pend_found, svc_found, grant;
    irq_idx_t pend_idx, svc_idx;

    irq_request_reg u_req (
        .clk        (clk),
        .rst_n      (rst_n),
        .irq_in     (irq_in),
        .level_mode (cfg_level),
        .ack_clr    (ack_onehot),
        .irr        (irr)
    );

    irq_prio_enc #(.W(IRQ_N)) u_pend_pick (
        .req   (req),
        .found (pend_found),
        .idx   (pend_idx)
    );

    irq_prio_enc #(.W(IRQ_N)) u_svc_pick (
        .req   (isr),
        .found (svc_found),
        .idx   (svc_idx)
    );

    irq_inservice_reg u_svc (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_bits (isr_set),
        .clr_bits (eoi_onehot),
        .isr      (isr)
    );

    always_comb begin
        req        = irr & ~s_q.imr;
        int_req    = pend_found && (!svc_found || (pend_idx < svc_idx));
        grant      = inta && int_req;
        ack_onehot = grant ? (irq_vec_t'(1) << pend_idx) : '0;
        eoi_onehot = (eoi && svc_found) ? (irq_vec_t'(1) << svc_idx) : '0;
        isr_set    = cfg_auto_eoi ? '0 : ack_onehot;

        s_d           = s_q;
        s_d.vec_valid = inta;
        if (mask_we) begin
            s_d.imr = mask_wdata;
        end
        if (grant) begin
            s_d.vec   = {cfg_base, pend_idx};
            s_d.slave = cfg_slave[pend_idx];
        end else if (inta) begin
            s_d.vec   = {cfg_base, {IDX_W{1'b1}}};
            s_d.slave = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vec_valid = s_q.vec_valid;
    assign vec_out   = s_q.vec;
    assign vec_slave = s_q.slave;
    assign irr_out   = irr;
    assign imr_out   = s_q.imr;
    assign isr_out   = isr;

    assert_mask_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int_req |-> ((irr_out & ~imr_out) != '0));

    assert_ack_enters_svc_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && int_req && !cfg_auto_eoi && !eoi)
        |=> ($countones(isr_out) == $countones($past(isr_out)) + 1));

    assert_eoi_drops_one_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi && !inta && isr_out != '0)
        |=> ($countones(isr_out) + 1 == $countones($past(isr_out))));

    assert_auto_keeps_svc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (inta && cfg_auto_eoi && !eoi) |=> (isr_out == $past(isr_out)));

    assert_vec_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        inta |=> vec_valid);

    assert_vec_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !inta |=> !vec_valid);
endmodule

// File: tb/sim_irq_resolver.sv
module sim_irq_resolver;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] irq_in = '0;
    logic       cfg_level = 1'b0;
    logic       cfg_auto_eoi = 1'b0;
    logic [4:0] cfg_base = 5'h12;
    logic [7:0] cfg_slave = 8'h04;
    logic       mask_we = 1'b0;
    logic [7:0] mask_wdata = '0;
    logic       eoi = 1'b0;
    logic       inta = 1'b0;
    logic       int_req, vec_valid, vec_slave;
    logic [7:0] vec_out, irr_out, imr_out, isr_out;

    int total = 0;
    int fails = 0;
    logic [8:0] sb[$];

    always #2.5 clk = ~clk;

    irq_resolver u0 (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cfg_level(cfg_level),
        .cfg_auto_eoi(cfg_auto_eoi), .cfg_base(cfg_base), .cfg_slave(cfg_slave),
        .mask_we(mask_we), .mask_wdata(mask_wdata), .eoi(eoi), .inta(inta),
        .int_req(int_req), .vec_valid(vec_valid), .vec_out(vec_out),
        .vec_slave(vec_slave), .irr_out(irr_out), .imr_out(imr_out), .isr_out(isr_out)
    );

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic pulse(input int i);
        irq_in[i] = 1'b1;
        tick();
        irq_in[i] = 1'b0;
        tick();
    endtask

    // driver: push expected {slave, vector}, then acknowledge
    task automatic ack(input logic [7:0] exp_vec, input logic exp_slave);
        sb.push_back({exp_slave, exp_vec});
        inta = 1'b1;
        tick();
        inta = 1'b0;
    endtask

    task automatic send_eoi();
        eoi = 1'b1;
        tick();
        eoi = 1'b0;
    endtask

    task automatic set_mask(input logic [7:0] m);
        mask_we = 1'b1;
        mask_wdata = m;
        tick();
        mask_we = 1'b0;
    endtask

    // monitor: compare each produced vector with the scoreboard
    always @(negedge clk) begin
        if (rst_n && vec_valid) begin
            if (sb.size() == 0) begin
                total++;
                fails++;
                $display("FAIL R9 actual=%0h expected=none", vec_out);
            end else begin
                logic [8:0] e;
                e = sb.pop_front();
                chk("R9/R11 vector", {23'd0, vec_slave, vec_out}, {23'd0, e});
            end
        end
    end

    initial begin
        #(200000 * 5);
        total++;
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        @(negedge clk);
        tick();
        tick();
        chk("R1 irr", irr_out, 0);
        chk("R1 imr", imr_out, 0);
        chk("R1 isr", isr_out, 0);
        chk("R1 int", int_req, 0);
        chk("R1 vec_valid", vec_valid, 0);
        rst_n = 1'b1;
        tick();

        // R2 edge capture and acknowledge
        pulse(3);
        chk("R2 latched", irr_out, 8'h08);
        chk("R2 int", int_req, 1);
        ack(8'h93, 1'b0);
        chk("R5 isr", isr_out, 8'h08);
        chk("R2 cleared on ack", irr_out, 8'h00);

        // R6 blocking by in-service level
        pulse(5);
        chk("R6 lower blocked", int_req, 0);
        pulse(3);
        chk("R6 equal blocked irr", irr_out, 8'h28);
        chk("R6 equal blocked", int_req, 0);
        pulse(1);
        chk("R6 higher passes", int_req, 1);
        ack(8'h91, 1'b0);
        chk("R5 nested isr", isr_out, 8'h0A);
        send_eoi();
        chk("R7 clears lowest", isr_out, 8'h08);
        chk("R6 still blocked", int_req, 0);
        send_eoi();
        chk("R7 empty", isr_out, 8'h00);
        chk("R6 released", int_req, 1);
        ack(8'h93, 1'b0);
        send_eoi();
        ack(8'h95, 1'b0);
        chk("R5 isr 5", isr_out, 8'h20);
        send_eoi();

        // R4 mask
        set_mask(8'h04);
        chk("R4 imr", imr_out, 8'h04);
        pulse(2);
        chk("R4 recorded", irr_out, 8'h04);
        chk("R4 silent", int_req, 0);
        set_mask(8'h00);
        chk("R4 unmasked", int_req, 1);
        ack(8'h92, 1'b1);
        send_eoi();

        // R10 spurious
        ack(8'h97, 1'b0);
        chk("R10 isr", isr_out, 8'h00);
        chk("R10 irr", irr_out, 8'h00);

        // R5 simultaneous requests
        irq_in[6] = 1'b1;
        irq_in[2] = 1'b1;
        tick();
        irq_in = '0;
        tick();
        chk("R5 both pending", irr_out, 8'h44);
        ack(8'h92, 1'b1);
        chk("R6 lower waits", int_req, 0);
        send_eoi();
        ack(8'h96, 1'b0);
        send_eoi();

        // R8 automatic release
        cfg_auto_eoi = 1'b1;
        pulse(6);
        ack(8'h96, 1'b0);
        chk("R8 isr untouched", isr_out, 8'h00);
        cfg_auto_eoi = 1'b0;

        // R2 held input does not retrigger
        irq_in[7] = 1'b1;
        tick();
        ack(8'h97, 1'b0);
        tick();
        chk("R2 no retrigger", irr_out, 8'h00);
        chk("R5 isr 7", isr_out, 8'h80);
        irq_in[7] = 1'b0;
        send_eoi();

        // R3 level mode
        cfg_level = 1'b1;
        irq_in[4] = 1'b1;
        tick();
        chk("R3 follows", irr_out, 8'h10);
        chk("R3 int", int_req, 1);
        irq_in[4] = 1'b0;
        tick();
        chk("R3 withdrawn", irr_out, 8'h00);
        chk("R3 int low", int_req, 0);
        irq_in[0] = 1'b1;
        tick();
        ack(8'h90, 1'b0);
        chk("R3 isr", isr_out, 8'h01);
        chk("R3 still high", irr_out, 8'h01);
        irq_in[0] = 1'b0;
        send_eoi();
        chk("R7 level eoi", isr_out, 8'h00);
        tick();
        chk("R3 dropped", irr_out, 8'h00);

        tick();
        chk("R9 scoreboard drained", sb.size(), 0);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule